// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit time of day counted in whole nanoseconds. On every enabled clock edge it adds a programmable increment that holds an integer part and a 32-bit binary fraction of a nanosecond. The fraction builds up in a separate accumulator, and its carry adds the odd extra nanosecond. Because of this the count stays in true nanoseconds for any driving clock period. For example, 0x01_9999_9999 gives 1.6 ns per tick, 0x03_3333_3333 gives 3.2 ns and 0x20_0000_0000 gives 32 ns. The count has no separate cycle counter and wraps modulo 2^64.

A host reaches the counter through a 32-bit register port. Split low and high words carry the 64-bit values with two atomicity rules:
- Reading the low time word captures the high word into a shadow, and the high-word read returns that shadow.
- Writing a low word (time or increment) only stages it. The high-word write commits the full 64-bit value in one cycle.

The running count is also driven out on a port so that timestamp logic can use it.

Top module: `tod_ns_counter`

## Requirements
- R1: While reset is applied, and after it is released, the time, the increment and the enable are all zero, so `tod_ns` reads 0 and the control, increment-low and increment-high registers read 0.
- R2: On each clock edge with the counter enabled, a 32-bit fraction accumulator adds increment bits [31:0]. The time adds increment bits [63:32] plus the carry out of that accumulator. N ticks after a time load with increment I, the time equals start + ((N*I) >> 32) modulo 2^64.
- R3: Control register bit 0 (address 0) enables counting. While it is 0 the time holds, and counting resumes at the edge after it is set again. The register reads back the bit.
- R4: An increment of zero stops the time from advancing even with the enable set.
- R5: A register read presents its data on `bus_rdata` one cycle after `bus_rd`. A read of the time-low word (address 1) returns time bits [31:0] and captures bits [63:32] into a shadow. A later read of the time-high word (address 2) returns that shadow, even if the time has moved on since.
- R6: A write to the time-low word only stages it, and the counter keeps running. A write to the time-high word loads {written high, staged low} at that edge. The load takes priority over the tick in that cycle and clears the fraction accumulator.
- R7: A write to the increment-low word (address 3) changes neither the rate nor the readable increment. A write to the increment-high word (address 4) commits {written high, staged low}. The edge of that write still uses the old increment, and the new value applies from the next edge. Both words read back the committed increment.
- R8: The time wraps from 2^64-1 through zero without stopping.
- R9: Reads of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| tod_ns | output | 64 | Current time in nanoseconds |

## Verification
Three host actions fall in the same cycle as a tick:
- a time-high write, which must override the tick that cycle and clear the fraction;
- an increment-high commit, whose own edge must still use the old increment;
- a time-low read, whose captured pair must both come from the value before that edge.

Every write and read in the bench lands while the counter runs. The output is therefore compared against values predicted from the edge count, and the rate is measured before and after each commit. The fraction-clear case is provoked by timing the load to an edge where the accumulator holds one half, so a missing clear shows as one extra nanosecond.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_TIME_LO = 3'd1,
    REG_TIME_HI = 3'd2,
    REG_INC_LO  = 3'd3,
    REG_INC_HI  = 3'd4
  } tod_reg_e;
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [BUS_W-1:0]     wdata_i,
  input  logic [2*BUS_W-1:0]   time_i,
  output logic [BUS_W-1:0]     rdata_o,
  output logic                 en_o,
  output logic [2*BUS_W-1:0]   inc_o,
  output logic                 load_o,
  output logic [2*BUS_W-1:0]   load_val_o
);
  localparam int unsigned WIDE_W = 2 * BUS_W;

  logic              en_q, en_d;
  logic [BUS_W-1:0]  time_stage_q, time_stage_d;
  logic [BUS_W-1:0]  inc_stage_q, inc_stage_d;
  logic [WIDE_W-1:0] inc_q, inc_d;
  logic [BUS_W-1:0]  shadow_q, shadow_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic [BUS_W-1:0]  rd_mux;

  logic wr_ctrl, wr_tlo, wr_thi, wr_ilo, wr_ihi, rd_tlo;

  always_comb begin
    wr_ctrl = wr_i && (addr_i == REG_CTRL);
    wr_tlo  = wr_i && (addr_i == REG_TIME_LO);
    wr_thi  = wr_i && (addr_i == REG_TIME_HI);
    wr_ilo  = wr_i && (addr_i == REG_INC_LO);
    wr_ihi  = wr_i && (addr_i == REG_INC_HI);
    rd_tlo  = rd_i && (addr_i == REG_TIME_LO);
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL:    rd_mux = BUS_W'(en_q);
      REG_TIME_LO: rd_mux = time_i[BUS_W-1:0];
      REG_TIME_HI: rd_mux = shadow_q;
      REG_INC_LO:  rd_mux = inc_q[BUS_W-1:0];
      REG_INC_HI:  rd_mux = inc_q[WIDE_W-1:BUS_W];
      default:     rd_mux = '0;
    endcase
  end

  always_comb begin
    en_d         = wr_ctrl ? wdata_i[0] : en_q;
    time_stage_d = wr_tlo  ? wdata_i : time_stage_q;
    inc_stage_d  = wr_ilo  ? wdata_i : inc_stage_q;
    inc_d        = wr_ihi  ? {wdata_i, inc_stage_q} : inc_q;
    shadow_d     = rd_tlo  ? time_i[WIDE_W-1:BUS_W] : shadow_q;
    rdata_d      = rd_i    ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= 1'b0;
      time_stage_q <= '0;
      inc_stage_q  <= '0;
      inc_q        <= '0;
      shadow_q     <= '0;
      rdata_q      <= '0;
    end else begin
      en_q         <= en_d;
      time_stage_q <= time_stage_d;
      inc_stage_q  <= inc_stage_d;
      inc_q        <= inc_d;
      shadow_q     <= shadow_d;
      rdata_q      <= rdata_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign en_o       = en_q;
  assign inc_o      = inc_q;
  assign load_o     = wr_thi;
  assign load_val_o = {wdata_i, time_stage_q};

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_tlo |=> (shadow_q == $past(time_i[WIDE_W-1:BUS_W]))); // R5
  AST_INC_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_ihi |=> $stable(inc_q)); // R7
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q)); // R5
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [TIME_W-1:0] inc_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int unsigned INT_W = TIME_W - FRAC_W;

  logic [TIME_W-1:0] time_q, time_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   frac_sum;
  logic [INT_W-1:0]  inc_int;
  logic              upd;

  assign inc_int = inc_i[TIME_W-1:FRAC_W];

  always_comb begin
    frac_sum = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};
    upd      = load_i || adv_i;
    if (load_i) begin
      time_d = load_val_i;
      frac_d = '0;
    end else begin
      time_d = time_q + TIME_W'(inc_int) + TIME_W'(frac_sum[FRAC_W]);
      frac_d = frac_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      frac_q <= '0;
    end else if (upd) begin
      time_q <= time_d;
      frac_q <= frac_d;
    end
  end

  assign time_o = time_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (time_q == $past(load_val_i)) && (frac_q == '0)); // R6
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(time_q)); // R3
  AST_ZERO_INC_STOPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && (inc_i == '0)) |=> $stable(time_q) && $stable(frac_q)); // R4
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (adv_i && !load_i) |=>
      ((time_q - $past(time_q)) == $past(TIME_W'(inc_int))) ||
      ((time_q - $past(time_q)) == $past(TIME_W'(inc_int)) + TIME_W'(1))); // R2
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter
  import tod_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic [2*BUS_W-1:0]  tod_ns
);
  localparam int unsigned TIME_W = 2 * BUS_W;
  localparam int unsigned FRAC_W = BUS_W;

  logic              rst_int_n;
  logic              en;
  logic [TIME_W-1:0] inc;
  logic              load;
  logic [TIME_W-1:0] load_val;
  logic [TIME_W-1:0] time_now;

  tod_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  tod_regif #(.BUS_W(BUS_W)) u_regif (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .addr_i     (bus_addr),
    .wr_i       (bus_wr),
    .rd_i       (bus_rd),
    .wdata_i    (bus_wdata),
    .time_i     (time_now),
    .rdata_o    (bus_rdata),
    .en_o       (en),
    .inc_o      (inc),
    .load_o     (load),
    .load_val_o (load_val)
  );

  tod_accum #(.TIME_W(TIME_W), .FRAC_W(FRAC_W)) u_accum (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .adv_i      (en),
    .inc_i      (inc),
    .load_i     (load),
    .load_val_i (load_val),
    .time_o     (time_now)
  );

  assign tod_ns = time_now;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |=> (tod_ns == '0)); // R1
endmodule

// File: tb/tod_ns_counter_tb.sv
module tod_ns_counter_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] tod_ns;

  int errors;
  int checks;
  bit done;

  localparam logic [2:0] A_CTRL = 3'd0, A_TLO = 3'd1, A_THI = 3'd2,
                         A_ILO = 3'd3, A_IHI = 3'd4;

  tod_ns_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_ns(tod_ns)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] exp_after(logic [63:0] start, logic [63:0] inc,
                                            int unsigned n);
    logic [127:0] p;
    p = 128'(n) * 128'(inc);
    return start + p[95:32];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_inc(logic [63:0] v);
    bus_write(A_ILO, v[31:0]);
    bus_write(A_IHI, v[63:32]);
  endtask

  task automatic load_time(logic [63:0] v);
    bus_write(A_TLO, v[31:0]);
    bus_write(A_THI, v[63:32]);
  endtask

  task automatic ticks(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] v, snap, inc, start;
    int unsigned n;
    errors = 0; checks = 0; done = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    ticks(4);
    check("R1 time in reset", tod_ns, 64'd0);
    rst_n = 1'b1;
    ticks(4);
    check("R1 time after reset", tod_ns, 64'd0);
    bus_read(A_CTRL, rd);  check("R1 enable reset", 64'(rd), 64'd0);
    bus_read(A_ILO, rd);   check("R1 inc low reset", 64'(rd), 64'd0);
    bus_read(A_IHI, rd);   check("R1 inc high reset", 64'(rd), 64'd0);

    // R9 unused addresses read zero
    bus_read(3'd7, rd);    check("R9 addr 7", 64'(rd), 64'd0);
    bus_read(3'd5, rd);    check("R9 addr 5", 64'(rd), 64'd0);

    bus_write(A_CTRL, 32'd1);
    bus_read(A_CTRL, rd);  check("R3 enable readback", 64'(rd), 64'd1);

    // R2 directed: the defined clock periods
    for (int k = 0; k < 3; k++) begin
      inc = (k == 0) ? 64'h01_9999_9999 : (k == 1) ? 64'h03_3333_3333 : 64'h20_0000_0000;
      set_inc(inc);
      load_time(64'd1000);
      check("R6 load value", tod_ns, 64'd1000);
      ticks(250);
      check("R2 defined period", tod_ns, exp_after(64'd1000, inc, 250));
    end

    // R2 and R5 random
    for (int t = 0; t < 24; t++) begin
      inc   = {($urandom % 8 == 0) ? $urandom : ($urandom % 64), $urandom};
      start = {$urandom, $urandom};
      n     = 1 + ($urandom % 300);
      set_inc(inc);
      load_time(start);
      check("R6 random load", tod_ns, start);
      ticks(n);
      check("R2 random advance", tod_ns, exp_after(start, inc, n));
      snap = tod_ns;
      bus_read(A_TLO, rd);  check("R5 low word", 64'(rd), 64'(snap[31:0]));
      ticks($urandom % 5);
      bus_read(A_THI, rd);  check("R5 high shadow", 64'(rd), 64'(snap[63:32]));
    end

    // R5 high word moves every tick, shadow must not
    set_inc({32'hFFFF_FFFF, 32'h0});
    load_time(64'h1234_5678_9ABC_DEF0);
    ticks(3);
    snap = tod_ns;
    bus_read(A_TLO, rd);   check("R5 fast low", 64'(rd), 64'(snap[31:0]));
    ticks(7);
    bus_read(A_THI, rd);   check("R5 fast shadow", 64'(rd), 64'(snap[63:32]));

    // R3 enable gating
    set_inc(64'h1_0000_0000);
    load_time(64'd500);
    bus_write(A_CTRL, 32'd0);
    v = tod_ns;
    ticks(20);
    check("R3 held while disabled", tod_ns, v);
    bus_read(A_CTRL, rd);  check("R3 enable cleared", 64'(rd), 64'd0);
    bus_write(A_CTRL, 32'd1);
    check("R3 no tick on enable edge", tod_ns, v);
    ticks(5);
    check("R3 resumed", tod_ns, v + 64'd5);

    // R6 low write only stages
    v = tod_ns;
    bus_write(A_TLO, 32'hDEAD_BEEF);
    check("R6 low write keeps running", tod_ns, v + 64'd1);

    // R7 increment staging and commit timing
    load_time(64'd0);
    bus_write(A_ILO, 32'h8000_0000);
    v = tod_ns;
    ticks(4);
    check("R7 rate unchanged by low", tod_ns, v + 64'd4);
    bus_read(A_ILO, rd);   check("R7 low not visible", 64'(rd), 64'd0);
    v = tod_ns;
    bus_write(A_IHI, 32'd3);
    check("R7 commit edge uses old", tod_ns, v + 64'd1);
    v = tod_ns;
    ticks(4);
    check("R7 new rate", tod_ns, v + 64'd14);
    bus_read(A_IHI, rd);   check("R7 high readback", 64'(rd), 64'd3);

    // R6 load clears fraction (accumulator at one half on the load edge)
    set_inc(64'h1_0000_0000);
    load_time(64'd0);
    bus_write(A_ILO, 32'h8000_0000);
    bus_write(A_IHI, 32'd0);
    ticks(1);
    bus_write(A_TLO, 32'd77);
    ticks(1);
    bus_write(A_THI, 32'd0);
    check("R6 load over tick", tod_ns, 64'd77);
    ticks(1);
    check("R6 fraction cleared", tod_ns, 64'd77);
    ticks(1);
    check("R6 fraction carry", tod_ns, 64'd78);

    // R4 zero increment
    set_inc(64'd0);
    v = tod_ns;
    ticks(30);
    check("R4 zero increment", tod_ns, v);

    // R8 wrap
    set_inc(64'h20_0000_0000);
    load_time(64'hFFFF_FFFF_FFFF_FFF0);
    ticks(1);
    check("R8 wrap", tod_ns, 64'h10);
    ticks(2);
    check("R8 after wrap", tod_ns, 64'h50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule